// File: doc/BRIEF.md
# Debounced Push-Button Incrementer with Hold-to-Repeat

This block turns a single raw, active-low time-setting push button into clean, one-cycle increment strobes for a time-of-day counter. The raw level is first brought into the system clock domain by a short flip-flop chain. A sample counter then filters out contact bounce: the debounced level moves only after the synchronized input has held a new value for a full filter window. Each debounced press gives exactly one increment.

If the button stays down, a hold timer starts on the debounced press. When the hold delay has run out, the block passes each strobe of an 8 Hz time base to its output, so holding the button steps the counter steadily. Releasing the button clears the timer, so every new press waits the full delay again. The block acts only while a set-mode enable is high. Dropping that enable in the middle of a hold cancels the repeat and clears the timer. One instance serves each settable field, for example minutes and hours.

Top module: `btn_repeat_inc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with the button up, `inc_o` is 0.
- R2: The button path has two synchronizer flops (`SYNC_STAGES` = 2), after which the debounced level changes only once the synchronized input has differed from it on `DEB_CYCLES` consecutive clock samples.
- R3: A bounce that holds the pressed (or released) level for fewer than `DEB_CYCLES` consecutive samples produces no increment.
- R4: With `set_mode` high, a debounced press edge gives exactly one `inc_o` pulse, one clock wide, in the cycle after the debounced level turns to pressed.
- R5: While `set_mode` is low, the button produces no `inc_o` pulse at all, however long it is held.
- R6: After the debounced press has lasted `HOLD_CYCLES` cycles in set mode, each one-cycle `tick_8hz` strobe seen while the press continues yields one `inc_o` pulse in the following cycle.
- R7: A debounced release clears the hold timer at once, so a new press must last a full `HOLD_CYCLES` before repeats start again.
- R8: Taking `set_mode` low while the button is held cancels the repeat and clears the hold timer. Raising `set_mode` again while the button is still held gives no immediate pulse and restarts the full hold delay.
- R9: A debounced release never produces an `inc_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Raw push button, low when pressed, asynchronous |
| tick_8hz | input | 1 | One-cycle strobe at the 8 Hz repeat rate |
| set_mode | input | 1 | High while the clock is stopped for setting |
| inc_o | output | 1 | Active-high one-cycle increment strobe |

## Verification
The hardest state to reach from the ports is a held button whose hold timer has already expired, followed by a change at exactly that point: a release, a drop of `set_mode`, or a bounce. With real delays this would take millions of cycles. The bench therefore shrinks `DEB_CYCLES` and `HOLD_CYCLES`, and runs its tick strobe period well below the hold delay. Directed holds that go past the delay are then interrupted by a release or by a `set_mode` drop. Random segments of glitches shorter than the filter, long holds and set-mode toggles follow, and every cycle is compared against a bench reference model.

// File: rtl/btnrep_pkg.sv
package btnrep_pkg;

    // Debounced button view handed from the filter to the repeat stage.
    typedef struct packed {
        logic level;   // 1 = pressed (debounced)
        logic rise;    // one-cycle strobe on the debounced press edge
    } deb_view_t;

endpackage

// File: rtl/btnrep_sync.sv
module btnrep_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic pressed_o
);
    localparam int N = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    typedef struct packed {
        logic [N-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (N == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = ~raw_n;
            end
        end else begin : g_chain
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[N-2:0], ~raw_n};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pressed_o = st_q.chain[N-1];

endmodule

// File: rtl/btnrep_debounce.sv
module btnrep_debounce
    import btnrep_pkg::*;
#(
    parameter int DEB_CYCLES = 1_250_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_i,
    output deb_view_t view_o
);
    localparam int DEB = (DEB_CYCLES < 1) ? 1 : DEB_CYCLES;
    localparam int CW  = $clog2(DEB + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          level;
        logic          rise;
    } deb_st_t;

    deb_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (sample_i != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = sample_i;
                st_d.cnt   = '0;
                st_d.rise  = sample_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view_o.level = st_q.level;
    assign view_o.rise  = st_q.rise;

    // R2
    level_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> ($past(sample_i) == st_q.level));

    // R2
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(DEB));

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |=> !st_q.rise);

endmodule

// File: rtl/btnrep_hold.sv
module btnrep_hold
    import btnrep_pkg::*;
#(
    parameter int HOLD_CYCLES = 93_750_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  deb_view_t view_i,
    input  logic      set_mode,
    input  logic      tick,
    output logic      inc_o
);
    localparam int HOLD = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
    localparam int HW   = $clog2(HOLD + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          armed;
        logic          inc;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     active;

    always_comb begin
        active = view_i.level & set_mode;
        st_d   = st_q;
        if (!active) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (!st_q.armed) begin
            if (st_q.cnt == LAST) st_d.armed = 1'b1;
            else                  st_d.cnt   = st_q.cnt + 1'b1;
        end
        st_d.inc = set_mode & (view_i.rise | (st_q.armed & tick & view_i.level));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign inc_o = st_q.inc;

    // R5
    inc_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inc |-> $past(set_mode));

    // R8
    leave_set_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_mode |=> (!st_q.armed && st_q.cnt == '0));

    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !view_i.level |=> (!st_q.armed && st_q.cnt == '0));

    // R9
    no_release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inc |-> $past(view_i.level));

endmodule

// File: rtl/btn_repeat_inc.sv
module btn_repeat_inc
    import btnrep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 1_250_000,
    parameter int HOLD_CYCLES = 93_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic tick_8hz,
    input  logic set_mode,
    output logic inc_o
);
    logic      pressed_sync;
    deb_view_t deb_view;

    btnrep_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_n     (btn_n),
        .pressed_o (pressed_sync)
    );

    btnrep_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (pressed_sync),
        .view_o   (deb_view)
    );

    btnrep_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .view_i   (deb_view),
        .set_mode (set_mode),
        .tick     (tick_8hz),
        .inc_o    (inc_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !inc_o);

endmodule

// File: tb/sim_btn_repeat_inc.sv
module sim_btn_repeat_inc;
    localparam int DEB  = 8;
    localparam int HOLD = 200;
    localparam int TICK = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic tick_8hz = 1'b0;
    logic set_mode = 1'b0;
    logic inc_o;

    always #4 clk = ~clk;

    btn_repeat_inc #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .tick_8hz(tick_8hz),
        .set_mode(set_mode), .inc_o(inc_o)
    );

    int    total = 0;
    int    bad   = 0;
    int    pulses = 0;
    int    prev_inc = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // tick strobe generator, driven away from the active edge
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK - 1) ? 0 : tick_cnt + 1;
        tick_8hz <= (tick_cnt == TICK - 1);
    end

    // Reference model built from the requirements
    logic m_p1, m_p2, m_deb, m_rise, m_exp;
    int   m_run, m_held;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= 0; m_p2 <= 0; m_deb <= 0; m_rise <= 0; m_exp <= 0;
            m_run <= 0; m_held <= 0;
        end else begin
            m_p1 <= ~btn_n;            // R2: two synchronizer flops
            m_p2 <= m_p1;
            if (m_p2 != m_deb && m_run + 1 >= DEB) begin
                m_deb  <= m_p2;
                m_run  <= 0;
                m_rise <= m_p2;
            end else begin
                m_run  <= (m_p2 != m_deb) ? m_run + 1 : 0;
                m_rise <= 1'b0;
            end
            if (m_deb && set_mode) m_held <= (m_held >= HOLD) ? HOLD : m_held + 1;
            else                   m_held <= 0;
            m_exp <= set_mode && (m_rise || (m_held >= HOLD && tick_8hz && m_deb));
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison and pulse counting
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) chk("R1 reset quiet", inc_o, 0);
            else begin
                chk(cur_req, inc_o, m_exp);
                if (inc_o && prev_inc != 0) chk("R4 width", 1, 0);
                if (inc_o) pulses++;
            end
            prev_inc = inc_o;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic press(int n);   btn_n = 1'b0; step(n); endtask
    task automatic release_b(int n); btn_n = 1'b1; step(n); endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        step(5);
        chk("R1 in reset", inc_o, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", inc_o, 0);
        set_mode = 1'b1;
        step(20);

        // R4: one short press, one pulse; R9: release gives none
        cur_req = "R4 single press";
        pulses = 0; press(60);
        chk("R4 press count", pulses, 1);
        cur_req = "R9 release";
        pulses = 0; release_b(60);
        chk("R9 release count", pulses, 0);

        // R3: glitches shorter than the filter window
        cur_req = "R3 bounce";
        pulses = 0;
        press(5); release_b(3); press(4); release_b(2); press(7); release_b(60);
        chk("R3 bounce count", pulses, 0);

        // R5: ignored outside set mode
        cur_req = "R5 not set";
        set_mode = 1'b0;
        pulses = 0; press(400); release_b(60);
        chk("R5 count", pulses, 0);
        set_mode = 1'b1; step(5);

        // R6: long hold repeats on ticks
        cur_req = "R6 repeat";
        pulses = 0; press(HOLD + 10 * TICK + 11);
        total++;
        if (pulses < 10 || pulses > 12) begin
            bad++;
            $display("FAIL R6 repeat count actual=%0d expected=10..12", pulses);
        end
        release_b(60);

        // R7: release restarts the delay
        cur_req = "R7 restart";
        pulses = 0; press(150); release_b(20); press(150); release_b(60);
        chk("R7 count", pulses, 2);

        // R8: leave set mode mid-repeat, come back still held
        cur_req = "R8 leave set";
        press(HOLD + 4 * TICK);
        set_mode = 1'b0; step(20);
        pulses = 0; set_mode = 1'b1; step(HOLD - 20);
        chk("R8 count", pulses, 0);
        release_b(60);

        // random segments
        cur_req = "R2 random";
        for (int i = 0; i < 300; i++) begin
            int len;
            len = (($urandom % 4) == 0) ? 150 + ($urandom % 400) : 1 + ($urandom % 20);
            btn_n = $urandom % 2;
            if (($urandom % 10) == 0) set_mode = ~set_mode;
            step(len);
        end
        release_b(60);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule